// File: doc/BRIEF.md
# Write-Through Parity-Protected Data Cache

This block is a small direct-mapped first-level data cache that sits between a load/store unit and a next-level memory. It never holds modified data: every store goes straight to the next level. A store that finds its word resident also updates the local copy. A store that misses leaves the cache untouched. Reads that hit return data one cycle after acceptance. Reads that miss fetch the whole line, install it, and then return the requested word.

Each stored word keeps one even-parity bit per byte. Because every line is clean, a read hit whose parity check fails is not repaired in place. It is handled like a miss: the line is fetched again from the next level, the good word is returned, and an error counter goes up by one. A test-only port flips one stored data bit so that this path can be exercised.

Top module: `l1wt_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, `nl_req_valid` is 0 and `perr_count` is 0.
- R2: On a read miss the block issues one next-level read whose address has its low log2(WORDS) bits at zero. It accepts WORDS beats in order, word 0 first, and installs them. It then pulses `resp_valid` with the requested word in the cycle after the last beat.
- R3: A read hit with good parity pulses `resp_valid` with the stored word in the cycle after acceptance and makes no next-level request.
- R4: Every store, hit or miss, issues exactly one next-level write carrying the store's address and data.
- R5: A store hit updates the resident word, so a later read of it returns the new data without a next-level request.
- R6: A store miss does not allocate. The line already held at that index still hits, and a read of the stored address misses and returns the stored data from the next level.
- R7: Each byte of a word has a stored even-parity bit, written on fill and on store-hit update. `flip_en` inverts data bit `flip_bit` of word `flip_word` in line `flip_line` and leaves the parity bit alone. A read hit whose parity fails is refetched like a miss and returns the correct data. Parity is checked per word, so a flipped word does not disturb reads of other words in the same line.
- R8: `perr_count` rises by exactly one for each read hit that fails parity and holds in every other case.
- R9: `req_ready` is low from the acceptance of a miss or store until it completes. A next-level request stays asserted, with stable address, data and direction, until `nl_req_ready` accepts it.
- R10: Each accepted access causes at most one next-level read request.
- R11: The line index is address bits [log2(WORDS)+log2(LINES)-1 : log2(WORDS)] and the tag is the bits above it. A miss to an index replaces the line that was there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Request accepted when high with req_valid |
| resp_valid | output | 1 | One-cycle load response |
| resp_rdata | output | DATA_W | Load data |
| nl_req_valid | output | 1 | Next-level request |
| nl_req_write | output | 1 | Next-level request is a write |
| nl_req_addr | output | ADDR_W | Next-level word address (line-aligned for reads) |
| nl_req_wdata | output | DATA_W | Next-level write data |
| nl_req_ready | input | 1 | Next level accepts the request |
| nl_resp_valid | input | 1 | Refill beat valid |
| nl_resp_data | input | DATA_W | Refill beat data |
| flip_en | input | 1 | Test-only bit flip strobe |
| flip_line | input | log2(LINES) | Line to corrupt |
| flip_word | input | log2(WORDS) | Word to corrupt |
| flip_bit | input | log2(DATA_W) | Bit to corrupt |
| perr_count | output | CNT_W | Parity errors detected |

## Verification
The bench sweeps every address of a 4-line, 4-word configuration in both orders. Each response and next-level read count is compared against a shadow tag model. A wrong index or tag split would show up as a miss where a hit is expected, or as stale data. A store sweep over all addresses checks write-through and checks that a store miss never evicts the resident line. A design that allocated on store misses would then skip a refill it owes. Every bit of one word is flipped in turn. A design that trusted the corrupted word, counted twice, or checked parity per line instead of per word would return bad data or a wrong error count.

// File: rtl/l1wt_pkg.sv
package l1wt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_FILL  = 2'd2,
    ST_WTHRU = 2'd3
  } l1wt_state_e;
endpackage

// File: rtl/l1wt_array.sv
module l1wt_array #(
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic              rd_perr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tag_we,
  input  logic [IDX_W-1:0]  tag_idx,
  input  logic [TAG_W-1:0]  tag_val,
  input  logic              flip_en,
  input  logic [IDX_W-1:0]  flip_idx,
  input  logic [OFF_W-1:0]  flip_off,
  input  logic [BIT_W-1:0]  flip_bit
);
  localparam int BYTES   = DATA_W / 8;
  localparam int ENTRIES = LINES * WORDS;
  localparam int AW      = IDX_W + OFF_W;

  logic [DATA_W-1:0] data_q [ENTRIES];
  logic [BYTES-1:0]  par_q  [ENTRIES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q;

  logic [AW-1:0]     rd_a, wr_a, flip_a;
  logic [BYTES-1:0]  wr_par, rd_chk;
  logic [DATA_W-1:0] flip_mask;

  assign rd_a      = {rd_idx, rd_off};
  assign wr_a      = {wr_idx, wr_off};
  assign flip_a    = {flip_idx, flip_off};
  assign flip_mask = DATA_W'(1) << flip_bit;

  // even parity: stored bit makes the count of ones in byte+bit even
  for (genvar b = 0; b < BYTES; b++) begin : g_par
    assign wr_par[b] = ^wr_data[8*b +: 8];
    assign rd_chk[b] = ^rd_data[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_q[wr_a] <= wr_data;
      par_q[wr_a]  <= wr_par;
    end
    if (flip_en && !(wr_en && (wr_a == flip_a))) begin
      data_q[flip_a] <= data_q[flip_a] ^ flip_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_q[tag_idx] <= tag_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid_q <= '0;
    else if (tag_we) valid_q[tag_idx] <= 1'b1;
  end

  assign rd_data  = data_q[rd_a];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_perr  = |(rd_chk ^ par_q[rd_a]);
endmodule

// File: rtl/l1wt_ctrl.sv
module l1wt_ctrl
  import l1wt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int CNT_W  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              nl_req_valid,
  output logic              nl_req_write,
  output logic [ADDR_W-1:0] nl_req_addr,
  output logic [DATA_W-1:0] nl_req_wdata,
  input  logic              nl_req_ready,
  input  logic              nl_resp_valid,
  input  logic [DATA_W-1:0] nl_resp_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [OFF_W-1:0]  rd_off,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic              rd_valid,
  input  logic              rd_perr,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [OFF_W-1:0]  wr_off,
  output logic [DATA_W-1:0] wr_data,
  output logic              tag_we,
  output logic [IDX_W-1:0]  tag_idx,
  output logic [TAG_W-1:0]  tag_val,
  output logic [CNT_W-1:0]  perr_count
);
  l1wt_state_e       state_q, state_d;
  logic [OFF_W-1:0]  beat_q, beat_d;
  logic              resp_valid_q, resp_valid_d;
  logic [CNT_W-1:0]  perr_q, perr_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, resp_data_q, resp_data_d;
  logic              req_load, resp_load;

  logic [IDX_W-1:0]  req_idx;
  logic [OFF_W-1:0]  req_off;
  logic [TAG_W-1:0]  req_tag;
  logic              hit, accept;

  assign req_off = req_addr[OFF_W-1:0];
  assign req_idx = req_addr[OFF_W +: IDX_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign rd_idx  = req_idx;
  assign rd_off  = req_off;
  assign hit     = rd_valid && (rd_tag == req_tag);
  assign accept  = req_valid && (state_q == ST_IDLE);
  assign tag_idx = addr_q[OFF_W +: IDX_W];
  assign tag_val = addr_q[ADDR_W-1 -: TAG_W];

  always_comb begin
    state_d      = state_q;
    beat_d       = beat_q;
    resp_valid_d = 1'b0;
    perr_d       = perr_q;
    req_load     = 1'b0;
    resp_load    = 1'b0;
    resp_data_d  = nl_resp_data;
    nl_req_valid = 1'b0;
    nl_req_write = 1'b0;
    nl_req_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    nl_req_wdata = wdata_q;
    wr_en        = 1'b0;
    wr_idx       = req_idx;
    wr_off       = req_off;
    wr_data      = req_wdata;
    tag_we       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          req_load = 1'b1;
          if (req_write) begin
            wr_en   = hit;
            state_d = ST_WTHRU;
          end else if (hit && !rd_perr) begin
            resp_valid_d = 1'b1;
            resp_load    = 1'b1;
            resp_data_d  = rd_data;
          end else begin
            if (hit) perr_d = perr_q + CNT_W'(1);
            state_d = ST_MREQ;
          end
        end
      end
      ST_MREQ: begin
        nl_req_valid = 1'b1;
        if (nl_req_ready) begin
          beat_d  = '0;
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        wr_idx = addr_q[OFF_W +: IDX_W];
        wr_off = beat_q;
        wr_data = nl_resp_data;
        if (nl_resp_valid) begin
          wr_en     = 1'b1;
          resp_load = (beat_q == addr_q[OFF_W-1:0]);
          beat_d    = beat_q + OFF_W'(1);
          if (beat_q == OFF_W'(WORDS - 1)) begin
            tag_we       = 1'b1;
            resp_valid_d = 1'b1;
            state_d      = ST_IDLE;
          end
        end
      end
      ST_WTHRU: begin
        nl_req_valid = 1'b1;
        nl_req_write = 1'b1;
        nl_req_addr  = addr_q;
        if (nl_req_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      beat_q       <= '0;
      resp_valid_q <= 1'b0;
      perr_q       <= '0;
    end else begin
      state_q      <= state_d;
      beat_q       <= beat_d;
      resp_valid_q <= resp_valid_d;
      perr_q       <= perr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_load) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
    if (resp_load) resp_data_q <= resp_data_d;
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign resp_valid = resp_valid_q;
  assign resp_rdata = resp_data_q;
  assign perr_count = perr_q;
endmodule

// File: rtl/l1wt_cache.sv
module l1wt_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int CNT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       req_ready,
  output logic                       resp_valid,
  output logic [DATA_W-1:0]          resp_rdata,
  output logic                       nl_req_valid,
  output logic                       nl_req_write,
  output logic [ADDR_W-1:0]          nl_req_addr,
  output logic [DATA_W-1:0]          nl_req_wdata,
  input  logic                       nl_req_ready,
  input  logic                       nl_resp_valid,
  input  logic [DATA_W-1:0]          nl_resp_data,
  input  logic                       flip_en,
  input  logic [$clog2(LINES)-1:0]   flip_line,
  input  logic [$clog2(WORDS)-1:0]   flip_word,
  input  logic [$clog2(DATA_W)-1:0]  flip_bit,
  output logic [CNT_W-1:0]           perr_count
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0]  rd_idx, wr_idx, tag_idx;
  logic [OFF_W-1:0]  rd_off, wr_off;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic [TAG_W-1:0]  rd_tag, tag_val;
  logic              rd_valid, rd_perr, wr_en, tag_we;

  l1wt_array #(
    .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)
  ) array_i (
    .clk(clk), .rst_n(rst_int_n),
    .rd_idx(rd_idx), .rd_off(rd_off), .rd_data(rd_data), .rd_tag(rd_tag),
    .rd_valid(rd_valid), .rd_perr(rd_perr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(wr_data),
    .tag_we(tag_we), .tag_idx(tag_idx), .tag_val(tag_val),
    .flip_en(flip_en), .flip_idx(flip_line), .flip_off(flip_word),
    .flip_bit(flip_bit)
  );

  l1wt_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS),
    .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_int_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .nl_req_valid(nl_req_valid), .nl_req_write(nl_req_write),
    .nl_req_addr(nl_req_addr), .nl_req_wdata(nl_req_wdata),
    .nl_req_ready(nl_req_ready), .nl_resp_valid(nl_resp_valid),
    .nl_resp_data(nl_resp_data),
    .rd_idx(rd_idx), .rd_off(rd_off), .rd_data(rd_data), .rd_tag(rd_tag),
    .rd_valid(rd_valid), .rd_perr(rd_perr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(wr_data),
    .tag_we(tag_we), .tag_idx(tag_idx), .tag_val(tag_val),
    .perr_count(perr_count)
  );
endmodule

// File: rtl/l1wt_cache_chk.sv
module l1wt_cache_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              nl_req_valid,
  input logic              nl_req_ready,
  input logic              nl_req_write,
  input logic [ADDR_W-1:0] nl_req_addr,
  input logic [DATA_W-1:0] nl_req_wdata,
  input logic [CNT_W-1:0]  perr_count
);
  localparam int OFF_W = $clog2(WORDS);

  logic [1:0] miss_reqs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miss_reqs_q <= 2'd0;
    else if (req_valid && req_ready) miss_reqs_q <= 2'd0;
    else if (nl_req_valid && nl_req_ready && !nl_req_write && miss_reqs_q != 2'd3)
      miss_reqs_q <= miss_reqs_q + 2'd1;
  end

  assert_ready_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nl_req_valid |-> !req_ready);

  assert_nl_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_req_valid && !nl_req_ready) |=>
      (nl_req_valid && $stable(nl_req_addr) && $stable(nl_req_write) &&
       $stable(nl_req_wdata)));

  assert_one_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_req_valid && nl_req_ready && !nl_req_write) |-> (miss_reqs_q == 2'd0));

  assert_line_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_req_valid && !nl_req_write) |-> (nl_req_addr[OFF_W-1:0] == '0));

  assert_resp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (req_ready && !nl_req_valid));

  assert_perr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_count != $past(perr_count)) |->
      ((perr_count - $past(perr_count)) == CNT_W'(1)));
endmodule

bind l1wt_cache l1wt_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .nl_req_valid(nl_req_valid),
  .nl_req_ready(nl_req_ready), .nl_req_write(nl_req_write),
  .nl_req_addr(nl_req_addr), .nl_req_wdata(nl_req_wdata),
  .perr_count(perr_count)
);

// File: tb/l1wt_cache_tb.sv
module l1wt_cache_tb_top;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int LINES  = 4;
  localparam int WORDS  = 4;
  localparam int CNT_W  = 8;
  localparam int NADDR  = 1 << ADDR_W;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ready, resp_valid;
  logic [DATA_W-1:0] resp_rdata;
  logic              nl_req_valid, nl_req_write;
  logic [ADDR_W-1:0] nl_req_addr;
  logic [DATA_W-1:0] nl_req_wdata;
  logic              nl_req_ready, nl_resp_valid;
  logic [DATA_W-1:0] nl_resp_data;
  logic              flip_en = 1'b0;
  logic [1:0]        flip_line = '0, flip_word = '0;
  logic [4:0]        flip_bit = '0;
  logic [CNT_W-1:0]  perr_count;

  l1wt_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS),
               .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .nl_req_valid(nl_req_valid), .nl_req_write(nl_req_write),
    .nl_req_addr(nl_req_addr), .nl_req_wdata(nl_req_wdata),
    .nl_req_ready(nl_req_ready), .nl_resp_valid(nl_resp_valid),
    .nl_resp_data(nl_resp_data), .flip_en(flip_en), .flip_line(flip_line),
    .flip_word(flip_word), .flip_bit(flip_bit), .perr_count(perr_count));

  function automatic logic [DATA_W-1:0] seed(int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A_0000;
  endfunction

  // next-level memory model with fixed latency
  logic [DATA_W-1:0] mem [NADDR];
  logic              m_busy;
  int                m_wait, m_beat, rd_cnt, wr_cnt;
  logic [ADDR_W-1:0] m_base;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NADDR; i++) mem[i] <= seed(i);
      m_busy <= 1'b0; m_wait <= 0; m_beat <= 0; m_base <= '0;
      rd_cnt <= 0; wr_cnt <= 0;
      nl_req_ready <= 1'b1; nl_resp_valid <= 1'b0; nl_resp_data <= '0;
    end else begin
      nl_resp_valid <= 1'b0;
      if (nl_req_valid && nl_req_ready) begin
        if (nl_req_write) begin
          mem[nl_req_addr] <= nl_req_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          rd_cnt <= rd_cnt + 1;
          m_busy <= 1'b1; m_wait <= LAT; m_beat <= 0; m_base <= nl_req_addr;
          nl_req_ready <= 1'b0;
        end
      end
      if (m_busy) begin
        if (m_wait != 0) m_wait <= m_wait - 1;
        else begin
          nl_resp_valid <= 1'b1;
          nl_resp_data  <= mem[m_base + ADDR_W'(m_beat)];
          m_beat <= m_beat + 1;
          if (m_beat == WORDS - 1) begin
            m_busy <= 1'b0;
            nl_req_ready <= 1'b1;
          end
        end
      end
    end
  end

  int total = 0, bad = 0;
  logic [DATA_W-1:0] smem [NADDR];
  logic [1:0]        btag [LINES];
  logic              bval [LINES];

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(int a, output logic [DATA_W-1:0] d, output int nreq,
                         output int wait_cyc);
    int r0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = rd_cnt;
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(a);
    @(negedge clk);
    req_valid = 1'b0;
    wait_cyc = 0;
    while (!resp_valid) begin @(negedge clk); wait_cyc++; end
    d = resp_rdata;
    nreq = rd_cnt - r0;
  endtask

  task automatic do_write(int a, logic [DATA_W-1:0] v, output int nwr,
                          output logic rdy_after);
    int w0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    w0 = wr_cnt;
    req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(a); req_wdata = v;
    @(negedge clk);
    req_valid = 1'b0;
    rdy_after = req_ready;
    while (!req_ready) @(negedge clk);
    nwr = wr_cnt - w0;
  endtask

  // read with expectations from the shadow tag model
  task automatic read_chk(int a, string tag);
    logic [DATA_W-1:0] d;
    int n, w, idx;
    logic miss;
    idx  = (a >> 2) & 3;
    miss = !(bval[idx] && btag[idx] == 2'(a >> 4));
    do_read(a, d, n, w);
    chk({tag, " data"}, d, smem[a]);
    chk({tag, " nl reads"}, 32'(n), miss ? 32'd1 : 32'd0);
    if (!miss) chk("R3 hit latency", 32'(w), 32'd0);
    bval[idx] = 1'b1; btag[idx] = 2'(a >> 4);
  endtask

  task automatic flip(int line, int word, int b);
    @(negedge clk);
    flip_en = 1'b1; flip_line = 2'(line); flip_word = 2'(word); flip_bit = 5'(b);
    @(negedge clk);
    flip_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] d, v;
    logic [CNT_W-1:0]  c0;
    logic              rdy;
    int n, w;
    for (int i = 0; i < NADDR; i++) smem[i] = seed(i);
    for (int i = 0; i < LINES; i++) begin bval[i] = 1'b0; btag[i] = '0; end
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 resp_valid", 32'(resp_valid), 32'd0);
    chk("R1 nl_req_valid", 32'(nl_req_valid), 32'd0);
    chk("R1 perr_count", 32'(perr_count), 32'd0);

    // R2 R3 R11: forward and reverse sweeps
    for (int a = 0; a < NADDR; a++) read_chk(a, "R2/R11 fwd");
    for (int a = NADDR - 1; a >= 0; a--) read_chk(a, "R3/R11 rev");

    // R4 R5: store hit (line 1 holds tag 0 now)
    v = 32'hDEAD_0005;
    do_write(5, v, n, rdy);
    smem[5] = v;
    chk("R9 ready low during store", 32'(rdy), 32'd0);
    chk("R4 store hit nl writes", 32'(n), 32'd1);
    chk("R4 store hit next-level data", mem[5], v);
    read_chk(5, "R5 store hit readback");

    // R6: store miss to idx 1, tag 2
    v = 32'hBEEF_0025;
    do_write(37, v, n, rdy);
    smem[37] = v;
    chk("R4 store miss nl writes", 32'(n), 32'd1);
    chk("R4 store miss next-level data", mem[37], v);
    read_chk(5, "R6 resident line kept");
    read_chk(37, "R6 no allocate");
    read_chk(5, "R11 conflict replaced");

    // R4 R6: store sweep over every address
    for (int a = 0; a < NADDR; a++) begin
      v = seed(a + 1000) ^ 32'h0F0F_F0F0;
      do_write(a, v, n, rdy);
      smem[a] = v;
      chk("R4 sweep nl writes", 32'(n), 32'd1);
      chk("R4 sweep next-level data", mem[a], v);
      read_chk(a, "R5/R6 sweep readback");
    end

    // R7 R8: every bit of word 0 in line 2 (address 8)
    read_chk(8, "R7 prime");
    for (int b = 0; b < DATA_W; b++) begin
      c0 = perr_count;
      flip(2, 0, b);
      do_read(8, d, n, w);
      chk("R7 corrected data", d, smem[8]);
      chk("R7 refetch count", 32'(n), 32'd1);
      chk("R8 perr increment", 32'(perr_count), 32'(c0 + CNT_W'(1)));
      do_read(8, d, n, w);
      chk("R7 clean after reload", 32'(n), 32'd0);
      chk("R8 perr hold", 32'(perr_count), 32'(c0 + CNT_W'(1)));
    end

    // R7: corruption is per word
    c0 = perr_count;
    flip(2, 1, 7);
    read_chk(10, "R7 other word unaffected");
    chk("R8 perr hold other word", 32'(perr_count), 32'(c0));
    do_read(9, d, n, w);
    chk("R7 flipped word data", d, smem[9]);
    chk("R7 flipped word refetch", 32'(n), 32'd1);
    chk("R8 perr after flipped word", 32'(perr_count), 32'(c0 + CNT_W'(1)));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule